// File: doc/BRIEF.md
# Brown-out reset sequencer

This block is the digital half of a supply supervisor. Every clock it receives a digitised supply level and compares it against one of two trip points. A configuration bit chooses between a low trip point near 2.7 V and a high one near 4.0 V. The comparison has hysteresis: the level must fall below a lower threshold to count as low, and must climb to a higher threshold to count as healthy again.

A sag raises the system reset only if it lasts longer than a minimum qualification time. Shorter sags are filtered out. Once reset is raised, it stays high until the supply has been healthy without a break for a programmable release time-out. A sticky flag records that the reset came from a brown-out, and software clears it with a write-one pulse.

An enable input switches the whole detector off. While it is off, the reset output is held low. After power-on, reset starts high and is released by the same time-out as after a brown-out.

Top module: `vdd_bor_seq`

## Requirements
- R1: While `rst_n` is low, `sys_rst_o` is 1 and `bo_flag_o` is 0.
- R2: When `hi_trip_sel` is 0, a healthy supply is judged low once `vlevel` is sampled below `LO_FALL` (default 500). When it is 1, the limit is `HI_FALL` (default 745).
- R3: Once judged low, the supply is judged healthy again only when `vlevel` is sampled at or above `LO_RISE` (512) or `HI_RISE` (760). Any level between the falling and rising limits keeps the low judgement.
- R4: A low judgement that lasts `DIP_CYC` (default 20) consecutive cycles or fewer leaves `sys_rst_o` at 0 and `bo_flag_o` unchanged.
- R5: On the cycle the low judgement lasts longer than `DIP_CYC` cycles, `sys_rst_o` goes to 1 with no further delay. Reset therefore rises at the edge `DIP_CYC`+2 after the first low sample.
- R6: While in reset, `sys_rst_o` falls only after the healthy judgement has lasted more than `REL_CYC` (default 64) consecutive cycles.
- R7: A low judgement during the release time-out keeps `sys_rst_o` at 1 and restarts the time-out from zero.
- R8: After `rst_n` is released, the release follows R6 from the first healthy judgement. This power-on release does not set `bo_flag_o`.
- R9: Sampling `det_en` low forces `sys_rst_o` to 0 at that edge and clears the low judgement. While disabled, no supply level raises reset.
- R10: `bo_flag_o` goes to 1 together with every reset raised by R5.
- R11: `bo_flag_o` holds until `flag_clr` is sampled 1, which clears it. A brown-out on the same edge wins, and the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; `vlevel` is sampled on every rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously upstream |
| det_en | input | 1 | 1 enables the detector; 0 turns it off and holds the reset output low |
| hi_trip_sel | input | 1 | 0 selects the low trip pair, 1 selects the high trip pair |
| vlevel | input | LVL_W | Digitised supply level |
| flag_clr | input | 1 | Write-one-to-clear pulse for the brown-out flag |
| sys_rst_o | output | 1 | Active-high system reset |
| bo_flag_o | output | 1 | Sticky flag: a brown-out reset has occurred |

## Verification
The bench targets the exact boundaries of both timers.

- **Qualification time.** A sag of exactly `DIP_CYC` cycles must be ignored, while one cycle more must trip. A design that is off by one trips on glitches or answers one cycle late.
- **Hysteresis band.** Levels parked between the two limits must neither release nor re-trigger. A design without hysteresis releases early.
- **Re-sag during release.** A brief re-sag in the middle of the release window must restart the time-out. A design that only pauses its counter releases too soon.
- **Flag and enable.** The bench hits a flag clear on the same edge as a brown-out, where clear-wins logic would lose the event. It also disables the detector both during a reset and during a sag, which a design without a forced exit would leave stuck in reset.

// File: rtl/bor_pkg.sv
package bor_pkg;

  typedef enum logic [1:0] {
    BS_RUN  = 2'd0,  // supply healthy, reset released
    BS_DIP  = 2'd1,  // supply low, qualifying the sag
    BS_HOLD = 2'd2,  // reset asserted, supply still low
    BS_REL  = 2'd3   // reset asserted, release time-out running
  } bor_state_e;

  function automatic int unsigned cnt_bits(input int unsigned a, input int unsigned b);
    int unsigned m;
    m = (a > b) ? a : b;
    return $clog2(m + 1);
  endfunction

endpackage

// File: rtl/bor_hyst_cmp.sv
module bor_hyst_cmp #(
  parameter int unsigned LVL_W   = 10,
  parameter int unsigned LO_FALL = 500,
  parameter int unsigned LO_RISE = 512,
  parameter int unsigned HI_FALL = 745,
  parameter int unsigned HI_RISE = 760
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             hi_sel_i,
  input  logic [LVL_W-1:0] level_i,
  output logic             under_o
);

  localparam logic [LVL_W-1:0] LO_F = LVL_W'(LO_FALL);
  localparam logic [LVL_W-1:0] LO_R = LVL_W'(LO_RISE);
  localparam logic [LVL_W-1:0] HI_F = LVL_W'(HI_FALL);
  localparam logic [LVL_W-1:0] HI_R = LVL_W'(HI_RISE);

  logic [LVL_W-1:0] fall_thr;
  logic [LVL_W-1:0] rise_thr;
  logic             under_q;
  logic             under_d;

  always_comb begin
    fall_thr = hi_sel_i ? HI_F : LO_F;
    rise_thr = hi_sel_i ? HI_R : LO_R;
  end

  // Low judgement with hysteresis; cleared when the detector is off.
  always_comb begin
    if (!en_i) begin
      under_d = 1'b0;
    end else if (under_q) begin
      under_d = (level_i < rise_thr);
    end else begin
      under_d = (level_i < fall_thr);
    end
  end

  // Power-on: supply presumed low until seen above the rising limit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      under_q <= 1'b1;
    end else begin
      under_q <= under_d;
    end
  end

  assign under_o = under_q;

endmodule

// File: rtl/bor_run_cnt.sv
module bor_run_cnt #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  // start loads one (the first counted cycle); step adds one.
  always_comb begin
    cnt_en = start_i | step_i;
    cnt_d  = start_i ? CNT_W'(1) : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/vdd_bor_seq.sv
module vdd_bor_seq #(
  parameter int unsigned LVL_W   = 10,
  parameter int unsigned LO_FALL = 500,
  parameter int unsigned LO_RISE = 512,
  parameter int unsigned HI_FALL = 745,
  parameter int unsigned HI_RISE = 760,
  parameter int unsigned DIP_CYC = 20,
  parameter int unsigned REL_CYC = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             det_en,
  input  logic             hi_trip_sel,
  input  logic [LVL_W-1:0] vlevel,
  input  logic             flag_clr,
  output logic             sys_rst_o,
  output logic             bo_flag_o
);

  import bor_pkg::*;

  localparam int unsigned CNT_W = cnt_bits(DIP_CYC, REL_CYC);
  localparam logic [CNT_W-1:0] DIP_LIM = CNT_W'(DIP_CYC);
  localparam logic [CNT_W-1:0] REL_LIM = CNT_W'(REL_CYC);

  logic             under;
  logic [CNT_W-1:0] cnt;
  logic             cnt_start;
  logic             cnt_step;
  logic             bo_set;
  bor_state_e       st_q;
  bor_state_e       st_d;
  logic             flag_q;
  logic             flag_d;
  logic             flag_en;

  bor_hyst_cmp #(
    .LVL_W  (LVL_W),
    .LO_FALL(LO_FALL),
    .LO_RISE(LO_RISE),
    .HI_FALL(HI_FALL),
    .HI_RISE(HI_RISE)
  ) u_cmp (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (det_en),
    .hi_sel_i(hi_trip_sel),
    .level_i (vlevel),
    .under_o (under)
  );

  bor_run_cnt #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(cnt_start),
    .step_i (cnt_step),
    .cnt_o  (cnt)
  );

  // Next-state logic: one counter serves both the sag and release windows.
  always_comb begin
    st_d      = st_q;
    cnt_start = 1'b0;
    cnt_step  = 1'b0;
    bo_set    = 1'b0;
    if (!det_en) begin
      st_d = BS_RUN;
    end else begin
      unique case (st_q)
        BS_RUN: begin
          if (under) begin
            st_d      = BS_DIP;
            cnt_start = 1'b1;
          end
        end
        BS_DIP: begin
          if (!under) begin
            st_d = BS_RUN;
          end else if (cnt == DIP_LIM) begin
            st_d   = BS_HOLD;
            bo_set = 1'b1;
          end else begin
            cnt_step = 1'b1;
          end
        end
        BS_HOLD: begin
          if (!under) begin
            st_d      = BS_REL;
            cnt_start = 1'b1;
          end
        end
        BS_REL: begin
          if (under) begin
            st_d = BS_HOLD;
          end else if (cnt == REL_LIM) begin
            st_d = BS_RUN;
          end else begin
            cnt_step = 1'b1;
          end
        end
        default: st_d = BS_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= BS_HOLD;
    end else begin
      st_q <= st_d;
    end
  end

  // Sticky flag: a brown-out on the same edge beats a clear.
  always_comb begin
    flag_en = bo_set | flag_clr;
    flag_d  = bo_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign sys_rst_o = (st_q == BS_HOLD) || (st_q == BS_REL);
  assign bo_flag_o = flag_q;

endmodule

// File: rtl/bor_seq_chk.sv
module bor_seq_chk #(
  parameter int unsigned DIP_CYC = 20,
  parameter int unsigned REL_CYC = 64
) (
  input logic clk,
  input logic rst_n,
  input logic det_en,
  input logic flag_clr,
  input logic sys_rst_o,
  input logic bo_flag_o,
  input logic under_i
);

  int unsigned low_run;
  int unsigned ok_run;

  // Window counters instead of long $past chains.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run <= 0;
      ok_run  <= 0;
    end else begin
      low_run <= (det_en && under_i && !sys_rst_o) ? low_run + 1 : 0;
      ok_run  <= (det_en && !under_i && sys_rst_o) ? ok_run + 1 : 0;
    end
  end

  AST_OFF_NO_RST: assert property (@(posedge clk) disable iff (!rst_n)
    !det_en |=> !sys_rst_o); // R9

  AST_DIP_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_o) |-> (low_run > DIP_CYC)); // R4

  AST_REL_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sys_rst_o) && $past(det_en)) |-> (ok_run > REL_CYC)); // R6

  AST_LOW_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst_o && det_en && under_i) |=> sys_rst_o); // R7

  AST_FLAG_ON_BO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_o) |-> bo_flag_o); // R10

  AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr |=> (!bo_flag_o || $rose(sys_rst_o))); // R11

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bo_flag_o && !flag_clr) |=> bo_flag_o); // R11

endmodule

bind vdd_bor_seq bor_seq_chk #(
  .DIP_CYC(DIP_CYC),
  .REL_CYC(REL_CYC)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .det_en   (det_en),
  .flag_clr (flag_clr),
  .sys_rst_o(sys_rst_o),
  .bo_flag_o(bo_flag_o),
  .under_i  (under)
);

// File: tb/vdd_bor_seq_test.sv
`timescale 1ns/1ps
module vdd_bor_seq_test;

  localparam int LVL_W   = 10;
  localparam int LO_FALL = 500;
  localparam int LO_RISE = 512;
  localparam int HI_FALL = 745;
  localparam int HI_RISE = 760;
  localparam int DIP_CYC = 20;
  localparam int REL_CYC = 64;

  logic             clk;
  logic             rst_n;
  logic             det_en;
  logic             hi_trip_sel;
  logic [LVL_W-1:0] vlevel;
  logic             flag_clr;
  logic             sys_rst_o;
  logic             bo_flag_o;

  int n_run;
  int n_fail;

  // reference model state
  bit m_u, m_r, m_f;
  int m_b, m_a;

  vdd_bor_seq #(
    .LVL_W(LVL_W), .LO_FALL(LO_FALL), .LO_RISE(LO_RISE),
    .HI_FALL(HI_FALL), .HI_RISE(HI_RISE),
    .DIP_CYC(DIP_CYC), .REL_CYC(REL_CYC)
  ) uut (
    .clk(clk), .rst_n(rst_n), .det_en(det_en), .hi_trip_sel(hi_trip_sel),
    .vlevel(vlevel), .flag_clr(flag_clr), .sys_rst_o(sys_rst_o),
    .bo_flag_o(bo_flag_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int fall_thr(input bit sel);
    return sel ? HI_FALL : LO_FALL;
  endfunction

  function automatic int rise_thr(input bit sel);
    return sel ? HI_RISE : LO_RISE;
  endfunction

  // One clock edge of the requirement-level model (R2..R11).
  task automatic model_edge();
    bit old_u;
    bit set;
    old_u = m_u;
    set   = 1'b0;
    if (!det_en) begin
      m_u = 1'b0; m_r = 1'b0; m_b = 0; m_a = 0;
    end else begin
      if (!m_r) begin
        m_b = old_u ? m_b + 1 : 0;
        if (m_b > DIP_CYC) begin
          m_r = 1'b1; set = 1'b1; m_b = 0; m_a = 0;
        end
      end else begin
        m_a = old_u ? 0 : m_a + 1;
        if (m_a > REL_CYC) begin
          m_r = 1'b0; m_a = 0; m_b = 0;
        end
      end
      if (old_u) m_u = (int'(vlevel) < rise_thr(hi_trip_sel));
      else       m_u = (int'(vlevel) < fall_thr(hi_trip_sel));
    end
    if (flag_clr) m_f = 1'b0;
    if (set)      m_f = 1'b1;
  endtask

  task automatic check(input string req);
    n_run++;
    if (sys_rst_o !== m_r || bo_flag_o !== m_f) begin
      n_fail++;
      $display("FAIL %s t=%0t: rst=%0b flag=%0b expected rst=%0b flag=%0b",
               req, $time, sys_rst_o, bo_flag_o, m_r, m_f);
    end
  endtask

  task automatic tick(input string req);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(req);
  endtask

  task automatic hold(input int lvl, input int n, input string req);
    vlevel = LVL_W'(lvl);
    for (int i = 0; i < n; i++) tick(req);
  endtask

  task automatic pulse_clr(input string req);
    flag_clr = 1'b1;
    tick(req);
    flag_clr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run=expired expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int seed_dummy;
    n_run = 0; n_fail = 0;
    seed_dummy = $urandom(32'd1234);
    rst_n = 1'b0; det_en = 1'b1; hi_trip_sel = 1'b0;
    vlevel = '0; flag_clr = 1'b0;
    m_u = 1'b1; m_r = 1'b1; m_f = 1'b0; m_b = 0; m_a = 0;
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1'b1;

    // R8: power-on release after the time-out, no flag
    hold(600, 10, "R8");
    hold(600, 70, "R8");
    // R4: exactly DIP_CYC low cycles are ignored
    hold(490, DIP_CYC, "R4");
    hold(600, 5, "R4");
    // R5 / R10: one more low cycle trips, flag set
    hold(490, DIP_CYC + 1, "R5");
    hold(490, 5, "R10");
    // R3: level inside the band holds reset
    hold(505, 100, "R3");
    // R6 / R7: re-sag during release restarts the window
    hold(520, 30, "R6");
    hold(490, 3, "R7");
    hold(520, REL_CYC, "R7");
    hold(520, 5, "R6");
    pulse_clr("R11");
    hold(600, 3, "R11");
    // R2: high trip pair
    hi_trip_sel = 1'b1;
    hold(700, 25, "R2");
    hold(750, 100, "R3");
    hold(770, 70, "R6");
    // R11: clear on the same edge as a new brown-out
    pulse_clr("R11");
    hold(700, DIP_CYC + 1, "R11");
    pulse_clr("R11");
    hold(700, 3, "R11");
    // R9: disable during reset, then a deep sag while off
    det_en = 1'b0;
    hold(700, 5, "R9");
    hold(400, 40, "R9");
    det_en = 1'b1;
    hold(800, 80, "R9");

    // constrained random segments
    for (int s = 0; s < 160; s++) begin
      int band, base, lvl, len;
      if ($urandom_range(0, 7) == 0) hi_trip_sel = ~hi_trip_sel;
      det_en = ($urandom_range(0, 15) != 0);
      band = $urandom_range(0, 3);
      base = (band[0]) ? rise_thr(hi_trip_sel) : fall_thr(hi_trip_sel);
      case (band)
        0: lvl = base - 1 - $urandom_range(0, 60);
        1: lvl = base + $urandom_range(0, 60);
        default: lvl = base - 3 + $urandom_range(0, 6);
      endcase
      len = $urandom_range(1, 90);
      vlevel = LVL_W'(lvl);
      for (int i = 0; i < len; i++) begin
        flag_clr = ($urandom_range(0, 7) == 0);
        tick("RND");
      end
      flag_clr = 1'b0;
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule